// File: doc/BRIEF.md
# Quad Setting Bank with Stored Copies

This block holds the four 8-bit working values that feed four DAC channels. Each working value has a matching stored copy, which stands for non-volatile storage: it is not cleared by the bank's reset and it changes only on a commit. A serial front end that is not part of this block hands over each received frame as a one-cycle strobe with a channel address and a data byte. The addressed working value takes the new byte at once. Any channel's working value can be read back on a separate read port.

The working values are temporary. When chip select is held low long enough to pass a glitch filter, all four working values reload from their stored copies on the same edge. A reset does the same reload. Each received frame is also held in a pending slot for two clocks. A programming request that arrives inside that window copies the frame into its channel's stored copy. If no request arrives in time, the pending frame is dropped. A read-only poll is a frame followed by a chip-select drop. It leaves the outputs where they were, provided the working and stored values agreed.

Top module: `setting_bank`

## Requirements
- R1: While `rst` is high, every channel of `chan_out` loads from its stored copy. Channel i occupies bits [8i+7:8i]. With default parameters and no commits, the stored copies are 0x10, 0x81, 0x5A and 0xC3 for channels 0 to 3.
- R2: A frame strobe (`frm_valid` high at a rising edge) puts `frm_data` into the channel selected by `frm_addr` (0 to 3) at that edge. The other channels keep their values.
- R3: While chip select stays high, any number of frames may be written to the channels in any order. Each channel holds the last byte written to it.
- R4: `rd_data` always shows the current working value of the channel selected by `rd_addr`.
- R5: When `cs_sel` stays low for at least FILT_CYC cycles after its two-stage synchroniser, all four working values reload from their stored copies on one edge.
- R6: A low pulse on `cs_sel` that covers no more than FILT_CYC-1 rising edges changes no working value.
- R7: `prog_req` high at the first or the second rising edge after a frame strobe copies that frame's byte into the addressed channel's stored copy.
- R8: `prog_req` first asserted at the third edge after a strobe, or later, changes no stored copy.
- R9: A commit does not change any working value.
- R10: A frame followed by a chip-select restore, with no commit, returns every channel to its stored value. If the frame wrote the stored value itself, the restore is a read-only poll and the output does not change.
- R11: The stored copies keep their contents through `rst`. A commit made before a reset is what the reset loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; reloads working values |
| cs_sel | input | 1 | Chip select, high = selected; asynchronous to clk |
| frm_valid | input | 1 | One-cycle strobe marking a complete received frame |
| frm_addr | input | 2 | Channel addressed by the frame |
| frm_data | input | 8 | Data byte of the frame |
| prog_req | input | 1 | Programming request from the sequencer |
| rd_addr | input | 2 | Channel selected for readback |
| rd_data | output | 8 | Working value of the selected channel |
| chan_out | output | 32 | Four working values, channel i at bits [8i+7:8i] |

## Verification
The assertions check the following on every cycle:
- the reset reload;
- that a strobe lands in the addressed channel;
- that the outputs hold when there is neither a strobe nor a restore;
- that a restore copies the stored values;
- that stored copies change only on a commit.

The bench scenarios cover the rest. They time chip-select pulses just under and well over the filter length. They place programming requests inside and just outside the two-clock window. They confirm a commit only indirectly, through a later restore or reset. They also show that a stored copy survives a reset.

// File: rtl/setting_bank_pkg.sv
package setting_bank_pkg;

    localparam int CH_N_DEF   = 4;
    localparam int DW_DEF     = 8;
    localparam int FILT_DEF   = 4;

    // Age of the pending frame: counts down from FIRST to IDLE.
    typedef enum logic [1:0] {
        PEND_IDLE  = 2'd0,
        PEND_LAST  = 2'd1,
        PEND_FIRST = 2'd2
    } pend_age_e;

    function automatic pend_age_e age_next(input pend_age_e a);
        case (a)
            PEND_FIRST: age_next = PEND_LAST;
            default:    age_next = PEND_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/sb_cs_filter.sv
module sb_cs_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_sel,
    output logic restore
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC);
    localparam logic [CW-1:0] FIRE  = CW'(FILT_CYC - 1);

    logic          sync1_q, sync2_q;
    logic [CW-1:0] low_cnt_q;
    logic          low_now;

    assign low_now = !sync2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q   <= 1'b0;
            sync2_q   <= 1'b0;
            low_cnt_q <= LIMIT;
        end else begin
            sync1_q <= cs_sel;
            sync2_q <= sync1_q;
            if (!low_now)
                low_cnt_q <= '0;
            else if (low_cnt_q != LIMIT)
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign restore = low_now && (low_cnt_q == FIRE);

endmodule

// File: rtl/sb_pending.sv
module sb_pending
    import setting_bank_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          frm_valid,
    input  logic [AW-1:0] frm_addr,
    input  logic [DW-1:0] frm_data,
    input  logic          prog_req,
    output logic          commit_en,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    pend_age_e     age_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            age_q <= PEND_IDLE;
        end else if (frm_valid) begin
            age_q  <= PEND_FIRST;
            addr_q <= frm_addr;
            data_q <= frm_data;
        end else if (age_q != PEND_IDLE) begin
            age_q <= prog_req ? PEND_IDLE : age_next(age_q);
        end
    end

    assign commit_en   = (age_q != PEND_IDLE) && prog_req && !flush && !rst;
    assign commit_addr = addr_q;
    assign commit_data = data_q;

endmodule

// File: rtl/setting_bank.sv
module setting_bank
    import setting_bank_pkg::*;
#(
    parameter int CH_N     = CH_N_DEF,
    parameter int DW       = DW_DEF,
    parameter int FILT_CYC = FILT_DEF,
    parameter logic [CH_N*DW-1:0] NV_INIT = 32'hC35A_8110
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_sel,
    input  logic                     frm_valid,
    input  logic [$clog2(CH_N)-1:0]  frm_addr,
    input  logic [DW-1:0]            frm_data,
    input  logic                     prog_req,
    input  logic [$clog2(CH_N)-1:0]  rd_addr,
    output logic [DW-1:0]            rd_data,
    output logic [CH_N*DW-1:0]       chan_out
);
    localparam int AW = $clog2(CH_N);

    logic          restore;
    logic          commit_en;
    logic [AW-1:0] commit_addr;
    logic [DW-1:0] commit_data;

    // Stored copies: never reset, written only by a commit.
    logic [CH_N*DW-1:0] nv_q = NV_INIT;
    logic [DW-1:0]      wk_q [CH_N];

    sb_cs_filter #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk     (clk),
        .rst     (rst),
        .cs_sel  (cs_sel),
        .restore (restore)
    );

    sb_pending #(.AW(AW), .DW(DW)) pend_i (
        .clk         (clk),
        .rst         (rst),
        .flush       (restore),
        .frm_valid   (frm_valid),
        .frm_addr    (frm_addr),
        .frm_data    (frm_data),
        .prog_req    (prog_req),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    always_ff @(posedge clk) begin
        if (commit_en)
            nv_q[commit_addr*DW +: DW] <= commit_data;
    end

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || restore)
                wk_q[i] <= nv_q[i*DW +: DW];
            else if (frm_valid && (frm_addr == AW'(i)))
                wk_q[i] <= frm_data;
        end
        assign chan_out[i*DW +: DW] = wk_q[i];
    end

    assign rd_data = wk_q[rd_addr];

endmodule

// File: rtl/setting_bank_chk.sv
module setting_bank_chk #(
    parameter int CH_N = 4,
    parameter int DW   = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frm_valid,
    input logic [$clog2(CH_N)-1:0]  frm_addr,
    input logic [DW-1:0]            frm_data,
    input logic [CH_N*DW-1:0]       chan_out,
    input logic [CH_N*DW-1:0]       nv_q,
    input logic                     restore,
    input logic                     commit_en
);
    localparam int AW = $clog2(CH_N);

    logic          wr_seen_q;
    logic [AW-1:0] wr_addr_q;
    logic [DW-1:0] wr_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen_q <= 1'b0;
        end else begin
            wr_seen_q <= frm_valid && !restore;
            wr_addr_q <= frm_addr;
            wr_data_q <= frm_data;
        end
    end

    // R1
    reset_reload_chk: assert property (@(posedge clk)
        rst |=> chan_out == $past(nv_q));

    // R2
    frame_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_seen_q |-> chan_out[wr_addr_q*DW +: DW] == wr_data_q);

    // R9
    outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_valid && !restore |=> $stable(chan_out));

    // R5
    restore_copy_chk: assert property (@(posedge clk) disable iff (rst)
        restore |=> chan_out == $past(nv_q));

    // R8
    stored_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit_en |=> $stable(nv_q));

endmodule

bind setting_bank setting_bank_chk #(.CH_N(CH_N), .DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_addr  (frm_addr),
    .frm_data  (frm_data),
    .chan_out  (chan_out),
    .nv_q      (nv_q),
    .restore   (restore),
    .commit_en (commit_en)
);

// File: tb/setting_bank_tb_top.sv
module setting_bank_tb_top;
    localparam int FILT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_sel = 1'b1;
    logic        frm_valid = 1'b0;
    logic [1:0]  frm_addr = '0;
    logic [7:0]  frm_data = '0;
    logic        prog_req = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [31:0] chan_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] wk_m [4];
    logic [7:0] nv_m [4];

    always #5 clk = ~clk;

    setting_bank #(.FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst(rst), .cs_sel(cs_sel), .frm_valid(frm_valid),
        .frm_addr(frm_addr), .frm_data(frm_data), .prog_req(prog_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_out(chan_out)
    );

    function automatic logic [31:0] pack_m(input logic [7:0] m [4]);
        return {m[3], m[2], m[1], m[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Frame strobe with optional programming request at edge k+delay (0 = none).
    task automatic frame(input logic [1:0] a, input logic [7:0] d, input int delay);
        @(negedge clk);
        frm_valid = 1'b1; frm_addr = a; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0;
        wk_m[a] = d;
        if (delay > 0) begin
            repeat (delay - 1) @(negedge clk);
            prog_req = 1'b1;
            @(negedge clk);
            prog_req = 1'b0;
            if (delay <= 2) nv_m[a] = d;
        end
    endtask

    task automatic cs_low(input int edges);
        @(negedge clk);
        cs_sel = 1'b0;
        repeat (edges) @(posedge clk);
        @(negedge clk);
        cs_sel = 1'b1;
        repeat (3) @(negedge clk);
        if (edges >= FILT + 3) for (int i = 0; i < 4; i++) wk_m[i] = nv_m[i];
    endtask

    initial begin
        nv_m = '{8'h10, 8'h81, 8'h5A, 8'hC3};
        wk_m = nv_m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset load", chan_out, pack_m(nv_m));

        frame(2'd2, 8'h3C, 0);
        chk("R2 single write", chan_out, pack_m(wk_m));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rd_addr = 2'(i); #1;
            chk("R4 readback", {24'h0, rd_data}, {24'h0, wk_m[i]});
        end

        void'($urandom(32'd514));
        for (int n = 0; n < 40; n++) begin
            frame(2'($urandom), 8'($urandom), 0);
            chk("R3 random writes", chan_out, pack_m(wk_m));
            rd_addr = 2'($urandom); #1;
            chk("R4 random readback", {24'h0, rd_data}, {24'h0, wk_m[rd_addr]});
        end

        cs_low(FILT - 1);
        chk("R6 short pulse ignored", chan_out, pack_m(wk_m));
        cs_low(FILT + 6);
        chk("R5 restore all", chan_out, pack_m(nv_m));

        frame(2'd1, 8'hA7, 1);
        chk("R9 commit keeps outputs", chan_out, pack_m(wk_m));
        frame(2'd3, 8'h4E, 2);
        frame(2'd0, 8'hEE, 3);
        chk("R2 after late request", chan_out, pack_m(wk_m));
        cs_low(FILT + 6);
        chk("R7 R8 commit window", chan_out, pack_m(nv_m));

        frame(2'd2, 8'h99, 0);
        cs_low(FILT + 6);
        chk("R10 uncommitted discarded", chan_out, pack_m(nv_m));
        frame(2'd1, nv_m[1], 0);
        cs_low(FILT + 6);
        chk("R10 read-only poll", chan_out, pack_m(nv_m));

        for (int n = 0; n < 12; n++) begin
            frame(2'($urandom), 8'($urandom), int'($urandom_range(0, 4)));
            if (n % 4 == 3) begin
                cs_low(FILT + 6);
                chk("R7 R8 random commit", chan_out, pack_m(nv_m));
            end
        end

        frame(2'd0, 8'h5F, 1);
        frame(2'd3, 8'h01, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        wk_m = nv_m;
        @(negedge clk);
        chk("R11 stored survives reset", chan_out, pack_m(nv_m));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule